// File: doc/BRIEF.md
# Duplex Digit-Pair Squarer

This block squares an unsigned operand and returns the full double-width result one register stage later. It avoids a general multiplier. The operand is cut into equal digits. Each result column then collects the products of the digit pairs whose positions sum to that column's index. A pair of two different digits appears twice in a full product array, so it is computed once and doubled by a one-bit left shift. A digit paired with itself enters once, as its square. The digit squares use the same rule inside the digit, at bit level. Columns are weighted by the digit width and summed into the final result.

With the default 4-bit digits and 16-bit operand, there are ten digit products: four squares and six cross pairs. The seven columns are added into a 32-bit square. Both sides of the block are valid/ready streams.

An input is accepted on a clock edge where `in_valid` and `in_ready` are both high. A result is consumed on an edge where `out_valid` and `out_ready` are both high. The single output slot takes a new operand when it is empty or is being drained in the same cycle. So `in_ready` follows `out_ready` combinationally. While the consumer stalls, the held result does not change.

Top module: `duplex_squarer`

## Requirements
- R1: For every accepted operand X, the result delivered for it on the output stream equals X*X as an unsigned 2*OP_W-bit value.
- R2: A result becomes valid on the clock edge right after its operand is accepted, so `out_valid` is high in the following cycle.
- R3: While `out_valid` is high and `out_ready` is low, on the next cycle `out_valid` stays high and `out_square` keeps its value.
- R4: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high.
- R5: While `rst_n` is low, and in the first cycle after it is released, `out_valid` is low.
- R6: Operand 0xFFFF gives 0xFFFE0001, and operand 0 gives 0.
- R7: `in_operand` has no effect while `in_valid` is low. When `in_ready` is high and `in_valid` is low, `out_valid` is low in the next cycle and no result is produced.
- R8: A single-bit operand 2^k gives 2^(2k), including k=15, where the only nonzero product is the square of the top digit.
- R9: Results leave in the order their operands were accepted, one result per accepted operand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand present on `in_operand` |
| in_ready | output | 1 | Block can take an operand this cycle |
| in_operand | input | OP_W (16) | Unsigned operand to square |
| out_valid | output | 1 | `out_square` holds a result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_square | output | 2*OP_W (32) | Unsigned square of the accepted operand |

## Verification
The bench builds the block with its default parameters: 4-bit digits and four digits, giving a 16-bit operand. At that size every one of the 65,536 operands can be pushed through and compared against a square computed in the bench. This covers every digit-pair combination in every column and every carry between columns. Boundary operands (zero, all ones, single bits, one full digit) go first. Random gaps on the input and random stalls on the output then exercise the hold, ready and idle rules on every cycle.

// File: rtl/duplex_sq_pkg.sv
package duplex_sq_pkg;

  // Number of distinct digit pairs (i >= j) for n digits.
  function automatic int pair_count(input int n);
    return (n * (n + 1)) / 2;
  endfunction

  // Flat slot index of the product of digit i and digit j, with i >= j.
  function automatic int pair_slot(input int i, input int j);
    return (i * (i + 1)) / 2 + j;
  endfunction

  // Width needed to hold one column sum.
  function automatic int column_width(input int digit_w, input int n);
    return 2 * digit_w + $clog2(n + 1) + 1;
  endfunction

endpackage

// File: rtl/digit_square.sv
module digit_square #(
  parameter int DW = 4,
  localparam int PW = 2 * DW
) (
  input  logic [DW-1:0] a,
  output logic [PW-1:0] sq
);

  // Bit-level duplex: each bit enters once at weight 2i, each bit pair
  // (i > j) enters once at weight i+j+1, the doubling folded into the shift.
  always_comb begin
    logic [PW-1:0] acc;
    acc = '0;
    for (int i = 0; i < DW; i++) begin
      acc = acc + (PW'(a[i]) << (2 * i));
      for (int j = 0; j < i; j++) begin
        acc = acc + (PW'(a[i] & a[j]) << (i + j + 1));
      end
    end
    sq = acc;
  end

  always_comb begin
    p_digit_square_r1: assert (sq == PW'(PW'(a) * PW'(a)));
  end

endmodule

// File: rtl/digit_mult.sv
module digit_mult #(
  parameter int DW = 4,
  localparam int PW = 2 * DW
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [PW-1:0] p
);

  // Shift-add array of DW partial products.
  logic [PW-1:0] partial [DW];

  generate
    for (genvar gi = 0; gi < DW; gi++) begin : g_row
      assign partial[gi] = b[gi] ? (PW'(a) << gi) : '0;
    end
  endgenerate

  always_comb begin
    logic [PW-1:0] acc;
    acc = '0;
    for (int i = 0; i < DW; i++) begin
      acc = acc + partial[i];
    end
    p = acc;
  end

  always_comb begin
    p_digit_mult_r1: assert (p == PW'(PW'(a) * PW'(b)));
  end

endmodule

// File: rtl/duplex_accum.sv
module duplex_accum
  import duplex_sq_pkg::*;
#(
  parameter int DW   = 4,
  parameter int NDIG = 4,
  localparam int OPW  = DW * NDIG,
  localparam int OW   = 2 * OPW
) (
  input  logic [OPW-1:0] operand,
  output logic [OW-1:0]  square
);

  localparam int PW   = 2 * DW;
  localparam int NP   = pair_count(NDIG);
  localparam int NCOL = 2 * NDIG - 1;
  localparam int CW   = column_width(DW, NDIG);
  localparam int AW   = OW + CW;

  logic [PW-1:0] prod [NP];
  logic [CW-1:0] col  [NCOL];

  // One product per unordered digit pair: squares on the diagonal,
  // general products off it.
  generate
    for (genvar gi = 0; gi < NDIG; gi++) begin : g_hi
      for (genvar gj = 0; gj <= gi; gj++) begin : g_lo
        localparam int SLOT = pair_slot(gi, gj);
        if (gi == gj) begin : g_sq
          digit_square #(.DW(DW)) u_sq (
            .a  (operand[gi*DW +: DW]),
            .sq (prod[SLOT])
          );
        end else begin : g_cross
          digit_mult #(.DW(DW)) u_mul (
            .a (operand[gi*DW +: DW]),
            .b (operand[gj*DW +: DW]),
            .p (prod[SLOT])
          );
        end
      end
    end
  endgenerate

  // Column k gathers pairs with i + j == k: a cross pair is doubled by
  // a shift, a diagonal term enters once.
  generate
    for (genvar gk = 0; gk < NCOL; gk++) begin : g_col
      always_comb begin
        logic [CW-1:0] sum;
        sum = '0;
        for (int i = 0; i < NDIG; i++) begin
          if ((gk - i) >= 0 && (gk - i) <= i) begin
            if ((gk - i) == i) begin
              sum = sum + CW'(prod[pair_slot(i, i)]);
            end else begin
              sum = sum + (CW'(prod[pair_slot(i, gk - i)]) << 1);
            end
          end
        end
        col[gk] = sum;
      end
    end
  endgenerate

  always_comb begin
    logic [AW-1:0] acc;
    acc = '0;
    for (int k = 0; k < NCOL; k++) begin
      acc = acc + (AW'(col[k]) << (DW * k));
    end
    square = acc[OW-1:0];
  end

  // Top column carries only the square of the top digit.
  always_comb begin
    p_top_column_r8: assert (col[NCOL-1] ==
                             CW'(PW'(operand[OPW-1 -: DW]) * PW'(operand[OPW-1 -: DW])));
  end

endmodule

// File: rtl/duplex_squarer.sv
module duplex_squarer #(
  parameter int DIGIT_W    = 4,
  parameter int NUM_DIGITS = 4,
  localparam int OP_W      = DIGIT_W * NUM_DIGITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [OP_W-1:0]   in_operand,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [2*OP_W-1:0] out_square
);

  localparam int RW = 2 * OP_W;

  logic [RW-1:0] square_comb;
  logic          take;

  duplex_accum #(.DW(DIGIT_W), .NDIG(NUM_DIGITS)) u_accum (
    .operand (in_operand),
    .square  (square_comb)
  );

  // Single output slot: free when empty or being drained this cycle.
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_square <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (take)     out_square <= square_comb;
    end
  end

  p_square_r1: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_square == RW'(RW'($past(in_operand)) * RW'($past(in_operand))));

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_square)));

  p_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> !out_valid);

endmodule

// File: tb/duplex_squarer_tb_top.sv
`timescale 1ns/1ps
module duplex_squarer_tb_top;

  localparam int OPW   = 16;
  localparam int NBND  = 8;
  localparam int TOTAL = NBND + 65536;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            in_valid;
  logic            in_ready;
  logic [OPW-1:0]  in_operand;
  logic            out_valid;
  logic            out_ready;
  logic [2*OPW-1:0] out_square;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;
  logic [OPW-1:0] op_q[$];

  always #2 clk = ~clk;

  duplex_squarer dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_operand (in_operand),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_square (out_square)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [OPW-1:0] item(input int n);
    logic [OPW-1:0] bnd [NBND] = '{16'h0000, 16'hFFFF, 16'h0001, 16'h8000,
                                   16'h00FF, 16'hFF00, 16'hF000, 16'h0010};
    if (n < NBND) return bnd[n];
    return OPW'(n - NBND);
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(760000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int  sent;
    bit  prev_stall, prev_take, prev_idle;
    logic [2*OPW-1:0] prev_data;
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_operand = '0;
    sent = 0; prev_stall = 0; prev_take = 0; prev_idle = 0; prev_data = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R5", longint'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R5", longint'(out_valid), 0);

    while (sent < TOTAL || op_q.size() > 0) begin
      if (prev_stall) check(out_valid && out_square == prev_data, "R3",
                            longint'(out_square), longint'(prev_data));
      if (prev_take)  check(out_valid == 1'b1, "R2", longint'(out_valid), 1);
      if (prev_idle)  check(out_valid == 1'b0, "R7", longint'(out_valid), 0);

      out_ready = ($urandom % 8) != 0;
      if (sent < TOTAL && ($urandom % 8) != 0) begin
        in_valid   = 1'b1;
        in_operand = item(sent);
      end else begin
        in_valid   = 1'b0;
        in_operand = OPW'($urandom);   // ignored while invalid (R7)
      end
      #1;
      check(in_ready == (!out_valid || out_ready), "R4",
            longint'(in_ready), longint'(!out_valid || out_ready));

      if (out_valid && out_ready) begin
        if (op_q.size() == 0) begin
          check(1'b0, "R9", longint'(out_square), 0);
        end else begin
          logic [OPW-1:0] op;
          longint expv;
          op   = op_q.pop_front();
          expv = longint'(op) * longint'(op);
          if (op == 16'hFFFF)
            check(out_square == 32'hFFFE0001, "R6", longint'(out_square), 64'hFFFE0001);
          else if (op == 16'h0000)
            check(out_square == 32'h0, "R6", longint'(out_square), 0);
          else if ((op & (op - 1)) == 0)
            check(longint'(out_square) == expv, "R8", longint'(out_square), expv);
          else
            check(longint'(out_square) == expv, "R1 R9", longint'(out_square), expv);
        end
      end
      prev_take = in_valid && in_ready;
      if (prev_take) begin
        op_q.push_back(in_operand);
        sent++;
      end
      prev_stall = out_valid && !out_ready;
      prev_idle  = in_ready && !in_valid;
      prev_data  = out_square;
      @(negedge clk);
    end

    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R7", longint'(out_valid), 0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule